// File: doc/BRIEF.md
# Protection and Trip Configuration Register with Write-Once Guard

This block holds the 32-bit configuration word that sets up output protection for a motor-control timer. It covers the dead-time code, the two trip inputs (enable, polarity, filter length, echo-to-pin selection), the safe-state selections, automatic re-arming and the main drive enable. Software loads the word through a plain write-enable port. The full word is always visible on a readback bus, and every field is also driven out on its own port to the rest of the timer.

A 2-bit guard level sits inside the word. It can be written only once after reset. After the first write of any kind it is frozen until the next reset. A nonzero guard level makes groups of fields ignore later writes. Level 1 protects the trip and dead-time setup. Levels 2 and 3 also protect the two safe-state selections.

Two bits are also driven by hardware. An external protection controller can set or clear the drive enable, and it can clear the release request. Several trip-related control bits reach their decoded output ports one clock after the register takes them.

Top module: `prot_cfg_reg`

## Requirements
- R1: While reset is applied and after it is released, the readback word and every decoded output are zero, including the guard level.
- R2: The guard level (bits 9:8) takes its value from the first write after reset. Every later write leaves it unchanged.
- R3: When the guard level is 1 or higher, writes leave these fields unchanged: gap code (bits 7:0), trip A enable (bit 12), trip A polarity (bit 13), auto arm (bit 14), trip A filter (bits 19:16), trip B filter (bits 23:20), trip B enable (bit 24), trip B polarity (bit 25), trip A echo (bit 28) and trip B echo (bit 29).
- R4: When the guard level is 2 or 3, writes also leave the safe idle select (bit 10) and the safe run select (bit 11) unchanged. Level 3 protects exactly the same fields as level 2.
- R5: At guard level 0 every implemented field takes the written value. Bit 27 and bits 31:30 always read zero.
- R6: The drive enable (bit 15) and the release request (bit 26) take the written value at any guard level.
- R7: The outputs trip_a_en, trip_a_pol, trip_b_en, trip_b_pol, release_req and trip_a_echo show the register content one clock later than the readback word. All other decoded outputs change in the same cycle as the readback word.
- R8: For the drive enable, a hardware clear overrides a software write and a hardware set. A software write overrides a hardware set. A hardware set on its own sets the bit.
- R9: A hardware clear of the release request overrides a software write of 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Word to write |
| drv_hw_set | input | 1 | Hardware set of the drive enable |
| drv_hw_clr | input | 1 | Hardware clear of the drive enable |
| rel_hw_clr | input | 1 | Hardware clear of the release request |
| rd_data | output | 32 | Current configuration word |
| gap_code | output | 8 | Dead-time code |
| guard_lvl | output | 2 | Write-guard level |
| safe_idle_sel | output | 1 | Safe-state select when drive is off |
| safe_run_sel | output | 1 | Safe-state select when drive is on |
| trip_a_en | output | 1 | Trip A enable (lagged) |
| trip_a_pol | output | 1 | Trip A polarity (lagged) |
| auto_arm | output | 1 | Automatic drive re-enable |
| drive_en | output | 1 | Main drive enable |
| trip_a_flt | output | 4 | Trip A filter setting |
| trip_b_flt | output | 4 | Trip B filter setting |
| trip_b_en | output | 1 | Trip B enable (lagged) |
| trip_b_pol | output | 1 | Trip B polarity (lagged) |
| release_req | output | 1 | Release request (lagged) |
| trip_a_echo | output | 1 | Trip A echo-to-pin mode (lagged) |
| trip_b_echo | output | 1 | Trip B echo-to-pin mode |

## Verification
The bench sweeps all four guard levels. At each level it follows the first write with a set of patterns that toggle every bit, so a wrong field grouping would let a protected field change or hold a free one. Bugs caught this way include a guard level that can be rewritten, level 3 dropping protection, and reserved bits that latch. After every write the lagged outputs are sampled twice: once before the extra clock, where they must still show the old word, and once after it. A missing or misplaced lag stage fails one of the two samples. Same-cycle collisions between hardware and software on the drive enable and on the release request expose a wrong priority order.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int WORD_W = 32;
  localparam int LVL_W  = 2;
  localparam int FLT_W  = 4;
  localparam int GAP_W  = 8;

  localparam int GAP_LSB     = 0;
  localparam int LVL_LSB     = 8;
  localparam int SIDLE_BIT   = 10;
  localparam int SRUN_BIT    = 11;
  localparam int TA_EN_BIT   = 12;
  localparam int TA_POL_BIT  = 13;
  localparam int AUTO_BIT    = 14;
  localparam int DRV_BIT     = 15;
  localparam int TA_FLT_LSB  = 16;
  localparam int TB_FLT_LSB  = 20;
  localparam int TB_EN_BIT   = 24;
  localparam int TB_POL_BIT  = 25;
  localparam int REL_BIT     = 26;
  localparam int TA_ECHO_BIT = 28;
  localparam int TB_ECHO_BIT = 29;

  localparam int TIER1_LVL = 1;
  localparam int TIER2_LVL = 2;
  localparam int LAG_W     = 6;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t span_mask(int lsb, int w);
    word_t m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  function automatic word_t bit_mask(int n);
    return span_mask(n, 1);
  endfunction

  localparam word_t IMPL_MASK = ~(bit_mask(27) | bit_mask(30) | bit_mask(31));
  localparam word_t LVL_MASK  = span_mask(LVL_LSB, LVL_W);
  localparam word_t TIER1_MASK =
      span_mask(GAP_LSB, GAP_W) | bit_mask(TA_EN_BIT) | bit_mask(TA_POL_BIT) |
      bit_mask(AUTO_BIT) | span_mask(TA_FLT_LSB, FLT_W) | span_mask(TB_FLT_LSB, FLT_W) |
      bit_mask(TB_EN_BIT) | bit_mask(TB_POL_BIT) | bit_mask(TA_ECHO_BIT) |
      bit_mask(TB_ECHO_BIT);
  localparam word_t TIER2_MASK = bit_mask(SIDLE_BIT) | bit_mask(SRUN_BIT);

  // Bits that reach their decoded port one clock late, packed for the lag line.
  function automatic logic [LAG_W-1:0] lag_pick(word_t w);
    return {w[TA_ECHO_BIT], w[REL_BIT], w[TB_POL_BIT], w[TB_EN_BIT],
            w[TA_POL_BIT], w[TA_EN_BIT]};
  endfunction
endpackage

// File: rtl/prot_cfg_rst_sync.sv
module prot_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/prot_cfg_guard.sv
module prot_cfg_guard
  import prot_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] lvl_q,
  output word_t            keep_mask
);
  logic used_q;
  logic used_d;

  always_comb begin
    used_d = used_q | wr_en;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    used_q <= 1'b0;
    else if (wr_en) used_q <= used_d;
  end

  // Fields whose current value survives a write.
  always_comb begin
    keep_mask = '0;
    if (used_q)                         keep_mask = keep_mask | LVL_MASK;
    if (int'(lvl_q) >= TIER1_LVL)       keep_mask = keep_mask | TIER1_MASK;
    if (int'(lvl_q) >= TIER2_LVL)       keep_mask = keep_mask | TIER2_MASK;
  end
endmodule

// File: rtl/prot_cfg_store.sv
module prot_cfg_store
  import prot_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ns,
  input  logic  wr_en,
  input  word_t wr_data,
  input  word_t keep_mask,
  input  logic  drv_set,
  input  logic  drv_clr,
  input  logic  rel_clr,
  output word_t word_q
);
  word_t word_d;
  logic  upd;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = (word_q & keep_mask) | (wr_data & ~keep_mask & IMPL_MASK);
    if (drv_clr)              word_d[DRV_BIT] = 1'b0;
    else if (!wr_en && drv_set) word_d[DRV_BIT] = 1'b1;
    if (rel_clr)              word_d[REL_BIT] = 1'b0;
    upd = wr_en | drv_set | drv_clr | rel_clr;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)  word_q <= '0;
    else if (upd) word_q <= word_d;
  end
endmodule

// File: rtl/prot_cfg_lag.sv
module prot_cfg_lag #(
  parameter int W     = 6,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_line
      logic [W-1:0] stage_q [DEPTH];
      logic [W-1:0] stage_d [DEPTH];
      always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_ns) begin
          if (!rst_ns) stage_q[g] <= '0;
          else         stage_q[g] <= stage_d[g];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/prot_cfg_reg.sv
module prot_cfg_reg
  import prot_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAG_CYCLES  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        drv_hw_set,
  input  logic        drv_hw_clr,
  input  logic        rel_hw_clr,
  output logic [31:0] rd_data,
  output logic [7:0]  gap_code,
  output logic [1:0]  guard_lvl,
  output logic        safe_idle_sel,
  output logic        safe_run_sel,
  output logic        trip_a_en,
  output logic        trip_a_pol,
  output logic        auto_arm,
  output logic        drive_en,
  output logic [3:0]  trip_a_flt,
  output logic [3:0]  trip_b_flt,
  output logic        trip_b_en,
  output logic        trip_b_pol,
  output logic        release_req,
  output logic        trip_a_echo,
  output logic        trip_b_echo
);
  logic             rst_n_sync;
  word_t            word_q;
  word_t            keep_mask;
  logic [LAG_W-1:0] lag_out;

  prot_cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_n_sync)
  );

  prot_cfg_guard u_guard (
    .clk(clk), .rst_ns(rst_n_sync), .wr_en(wr_en),
    .lvl_q(word_q[LVL_LSB +: LVL_W]), .keep_mask(keep_mask)
  );

  prot_cfg_store u_store (
    .clk(clk), .rst_ns(rst_n_sync), .wr_en(wr_en), .wr_data(wr_data),
    .keep_mask(keep_mask), .drv_set(drv_hw_set), .drv_clr(drv_hw_clr),
    .rel_clr(rel_hw_clr), .word_q(word_q)
  );

  prot_cfg_lag #(.W(LAG_W), .DEPTH(LAG_CYCLES)) u_lag (
    .clk(clk), .rst_ns(rst_n_sync), .din(lag_pick(word_q)), .dout(lag_out)
  );

  assign rd_data       = word_q;
  assign gap_code      = word_q[GAP_LSB +: GAP_W];
  assign guard_lvl     = word_q[LVL_LSB +: LVL_W];
  assign safe_idle_sel = word_q[SIDLE_BIT];
  assign safe_run_sel  = word_q[SRUN_BIT];
  assign auto_arm      = word_q[AUTO_BIT];
  assign drive_en      = word_q[DRV_BIT];
  assign trip_a_flt    = word_q[TA_FLT_LSB +: FLT_W];
  assign trip_b_flt    = word_q[TB_FLT_LSB +: FLT_W];
  assign trip_b_echo   = word_q[TB_ECHO_BIT];
  assign {trip_a_echo, release_req, trip_b_pol, trip_b_en, trip_a_pol, trip_a_en} = lag_out;
endmodule

// File: rtl/prot_cfg_chk.sv
module prot_cfg_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       wr_en,
  input logic       drv_hw_clr,
  input logic       rel_hw_clr,
  input logic       rd_ta_en,
  input logic       rd_rel,
  input logic [1:0] guard_lvl,
  input logic [7:0] gap_code,
  input logic [3:0] trip_a_flt,
  input logic       safe_idle_sel,
  input logic       safe_run_sel,
  input logic       trip_a_en,
  input logic       release_req,
  input logic       drive_en
);
  logic seen_wr;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    seen_wr <= 1'b0;
    else if (wr_en) seen_wr <= 1'b1;
  end

  a_r2_guard_frozen: assert property (@(posedge clk) disable iff (!rst_ns)
    seen_wr |=> $stable(guard_lvl));

  a_r3_tier1_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && guard_lvl != 2'd0) |=> ($stable(gap_code) && $stable(trip_a_flt)));

  a_r4_tier2_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && guard_lvl[1]) |=> ($stable(safe_idle_sel) && $stable(safe_run_sel)));

  a_r7_trip_lag: assert property (@(posedge clk) disable iff (!rst_ns)
    trip_a_en == $past(rd_ta_en));

  a_r7_release_lag: assert property (@(posedge clk) disable iff (!rst_ns)
    release_req == $past(rd_rel));

  a_r8_drive_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    drv_hw_clr |=> !drive_en);

  a_r9_release_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    rel_hw_clr |=> !rd_rel);
endmodule

bind prot_cfg_reg prot_cfg_chk u_chk (
  .clk(clk), .rst_ns(rst_n_sync), .wr_en(wr_en), .drv_hw_clr(drv_hw_clr),
  .rel_hw_clr(rel_hw_clr), .rd_ta_en(rd_data[12]), .rd_rel(rd_data[26]),
  .guard_lvl(guard_lvl), .gap_code(gap_code), .trip_a_flt(trip_a_flt),
  .safe_idle_sel(safe_idle_sel), .safe_run_sel(safe_run_sel),
  .trip_a_en(trip_a_en), .release_req(release_req), .drive_en(drive_en)
);

// File: tb/test_prot_cfg_reg.sv
module test_prot_cfg_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        drv_hw_set = 1'b0, drv_hw_clr = 1'b0, rel_hw_clr = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  gap_code;
  logic [1:0]  guard_lvl;
  logic        safe_idle_sel, safe_run_sel, trip_a_en, trip_a_pol, auto_arm, drive_en;
  logic [3:0]  trip_a_flt, trip_b_flt;
  logic        trip_b_en, trip_b_pol, release_req, trip_a_echo, trip_b_echo;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model;
  logic        used;

  always #2 clk = ~clk;

  prot_cfg_reg i_prot_cfg_reg (.*);

  function automatic logic [31:0] next_word(logic [31:0] old, logic [31:0] d,
                                            logic wrote, logic [1:0] lvl);
    logic [31:0] keep;
    keep = 32'h0;
    if (wrote)     keep |= 32'h0000_0300;
    if (lvl >= 1)  keep |= 32'h33FF_70FF;
    if (lvl >= 2)  keep |= 32'h0000_0C00;
    return (old & keep) | (d & ~keep & 32'h37FF_FFFF);
  endfunction

  function automatic logic [5:0] lag_bits(logic [31:0] m);
    return {m[28], m[26], m[25], m[24], m[13], m[12]};
  endfunction

  function automatic logic [21:0] now_bits(logic [31:0] m);
    return {m[7:0], m[9:8], m[10], m[11], m[14], m[15], m[19:16], m[23:20], m[29]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] lag_port();
    return {trip_a_echo, release_req, trip_b_pol, trip_b_en, trip_a_pol, trip_a_en};
  endfunction

  function automatic logic [21:0] now_port();
    return {gap_code, guard_lvl, safe_idle_sel, safe_run_sel, auto_arm, drive_en,
            trip_a_flt, trip_b_flt, trip_b_echo};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model = '0;
    used  = 1'b0;
    chk("R1 readback", rd_data, 32'h0);
    chk("R1 outputs", {10'h0, now_port()} | {26'h0, lag_port()}, 32'h0);
  endtask

  task automatic wr(logic [31:0] d);
    logic [31:0] prev;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    prev  = model;
    model = next_word(model, d, used, model[9:8]);
    used  = 1'b1;
    chk("R2 R3 R4 R5 R6 readback", rd_data, model);
    chk("R7 same-cycle fields", {10'h0, now_port()}, {10'h0, now_bits(model)});
    chk("R7 lagged before", {26'h0, lag_port()}, {26'h0, lag_bits(prev)});
    @(negedge clk);
    chk("R7 lagged after", {26'h0, lag_port()}, {26'h0, lag_bits(model)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int lv = 0; lv < 4; lv++) begin
      do_reset();
      wr(32'hFFFF_FCFF | (32'(lv) << 8));
      chk("R2 first write", {30'h0, guard_lvl}, 32'(lv));
      wr(32'h0000_0000);
      wr(32'hFFFF_FFFF);
      wr(32'hA5A5_5A5A);
      wr(32'h5A5A_A5A5);
      wr(32'h1234_5678);
      wr(32'h0000_0000);
      chk("R2 frozen", {30'h0, guard_lvl}, 32'(lv));
    end

    // Guard level 3 now; hardware controls on drive enable and release request.
    drv_hw_clr = 1'b1; wr_en = 1'b1; wr_data = model | 32'h0000_8000;
    @(negedge clk);
    drv_hw_clr = 1'b0; wr_en = 1'b0;
    chk("R8 clear beats write", {31'h0, drive_en}, 32'h0);
    drv_hw_set = 1'b1;
    @(negedge clk);
    drv_hw_set = 1'b0;
    chk("R8 set alone", {31'h0, drive_en}, 32'h1);
    drv_hw_set = 1'b1; drv_hw_clr = 1'b1;
    @(negedge clk);
    drv_hw_set = 1'b0; drv_hw_clr = 1'b0;
    chk("R8 clear beats set", {31'h0, drive_en}, 32'h0);
    drv_hw_set = 1'b1;
    @(negedge clk);
    drv_hw_set = 1'b1; wr_en = 1'b1; wr_data = model & ~32'h0000_8000;
    @(negedge clk);
    drv_hw_set = 1'b0; wr_en = 1'b0;
    chk("R8 write beats set", {31'h0, drive_en}, 32'h0);
    model[15] = 1'b0;
    wr(model | 32'h0400_0000);
    chk("R6 release set at level 3", {31'h0, rd_data[26]}, 32'h1);
    rel_hw_clr = 1'b1; wr_en = 1'b1; wr_data = model | 32'h0400_0000;
    @(negedge clk);
    rel_hw_clr = 1'b0; wr_en = 1'b0;
    chk("R9 clear beats write", {31'h0, rd_data[26]}, 32'h0);
    @(negedge clk);
    chk("R9 lagged release", {31'h0, release_req}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule